// File: doc/BRIEF.md
# Sequential Shift-Add Multiplier

This block multiplies two `WIDTH`-bit operands and returns a `2*WIDTH`-bit product. It has one adder and one double-width partial-product register. The multiplier operand sits in the low half of that register. Each clock cycle the block handles one multiplier bit: it adds either zero or the multiplicand into the upper half, then shifts the whole register right by one place. A run therefore takes exactly `WIDTH` cycles after it is accepted. The right shift is built into the register's input wiring, so no separate shift cycle is needed.

A mode input selects how the operands are read. In unsigned mode the adder's carry-out becomes the new top bit of the register. In two's-complement mode the upper half is sign-extended before each addition. On the last step, where the multiplier's top bit carries negative weight, the block subtracts instead of adding.

A caller drives the operands and the mode with a one-cycle `start` while the block is idle. It then waits for the one-cycle `done` pulse. The product stays on the output until the next accepted start.

Top module: `seq_shift_add_mul`

## Requirements
- R1: After reset, `busy`, `done` and `product` are all 0.
- R2: A `start` sampled while `busy` is low is accepted. `busy` is high from the next cycle for exactly `WIDTH` cycles.
- R3: `done` is high for exactly one cycle: the first cycle after the final iteration, in which `busy` is already low. `done` and `busy` are never high together.
- R4: With `sgn_mode` = 0, `product` equals the unsigned product of `mcand` and `mplier`, and no carry is lost. For example, for `WIDTH`=4, 1111 × 1111 gives 11100001 and 1010 × 0011 gives 00011110.
- R5: With `sgn_mode` = 1, both operands are two's-complement numbers and `product` is their two's-complement product. For example, for `WIDTH`=4, 1010 × 1011 gives 00011110 (+30), 1000 × 1000 gives 01000000 (+64), and 1000 × 0111 gives 11001000 (−56).
- R6: A `start` sampled while `busy` is high is ignored. Operands or mode presented with it do not change the running computation or its result.
- R7: While the block is idle and `start` is low, `product` holds the last result, whatever `mcand`, `mplier` and `sgn_mode` do.
- R8: A `start` sampled in the same cycle as the `done` pulse is accepted and begins a new run, which produces a correct result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request to begin a multiplication; accepted only when idle |
| sgn_mode | input | 1 | 1 = two's-complement operands, 0 = unsigned operands |
| mcand | input | WIDTH | Multiplicand |
| mplier | input | WIDTH | Multiplier |
| busy | output | 1 | An iteration is in progress |
| done | output | 1 | One-cycle pulse when the product is complete |
| product | output | 2*WIDTH | Product register (holds the result once done) |

## Verification
The completion pulse and the acceptance of a new request can fall in the same cycle. The bench provokes this by raising `start` in the very cycle in which `done` is high. It judges the overlap by three observations:
- `done` lasts only that one cycle.
- `busy` rises on the next cycle.
- The second run's product is correct.

A second overlap is a request arriving mid-run. It is provoked with different operands and the opposite mode, and judged by the first run's product being unchanged.

// File: rtl/mul_pkg.sv
package mul_pkg;

    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_TWOS     = 1'b1
    } mul_mode_e;

    // Counter width needed to hold the iteration count w.
    function automatic int cnt_bits(input int w);
        return $clog2(w) + 1;
    endfunction

endpackage

// File: rtl/mul_step_ctrl.sv
module mul_step_ctrl #(
    parameter int WIDTH = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic accept,
    output logic step,
    output logic last,
    output logic busy,
    output logic done
);
    localparam int CW = mul_pkg::cnt_bits(WIDTH);

    typedef struct packed {
        logic          busy;
        logic          done;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        accept    = start && !st_q.busy;
        step      = st_q.busy;
        last      = st_q.busy && (st_q.cnt == CW'(1));
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.cnt  = CW'(WIDTH);
        end else if (st_q.busy) begin
            st_d.cnt = st_q.cnt - CW'(1);
            if (last) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy = st_q.busy;
    assign done = st_q.done;

    // R3
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    done_busy_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && busy));
    // R2
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last) |=> busy);
    // R2
    cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (st_q.cnt != '0));

endmodule

// File: rtl/mul_addsub.sv
module mul_addsub #(
    parameter int WIDTH = 16
) (
    input  logic             sgn,
    input  logic             use_add,
    input  logic             negate,
    input  logic [WIDTH-1:0] acc,
    input  logic [WIDTH-1:0] addend,
    output logic [WIDTH:0]   sum
);
    logic [WIDTH-1:0] sel;
    logic [WIDTH:0]   acc_x, add_x;

    always_comb begin
        sel   = use_add ? addend : '0;
        acc_x = {sgn & acc[WIDTH-1], acc};
        add_x = {sgn & sel[WIDTH-1], sel};
        sum   = negate ? (acc_x - add_x) : (acc_x + add_x);
    end

endmodule

// File: rtl/mul_pp_reg.sv
module mul_pp_reg #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic               step,
    input  logic               last,
    input  logic               sgn_in,
    input  logic [WIDTH-1:0]   x_in,
    input  logic [WIDTH-1:0]   y_in,
    output logic [2*WIDTH-1:0] pp
);
    localparam int PW = 2 * WIDTH;

    typedef struct packed {
        logic             sgn;
        logic [WIDTH-1:0] mcand;
        logic [PW-1:0]    pp;
    } dp_t;

    dp_t dp_d, dp_q;
    logic [WIDTH:0] sum;

    mul_addsub #(.WIDTH(WIDTH)) addsub_i (
        .sgn     (dp_q.sgn),
        .use_add (dp_q.pp[0]),
        .negate  (dp_q.sgn && last),
        .acc     (dp_q.pp[PW-1:WIDTH]),
        .addend  (dp_q.mcand),
        .sum     (sum)
    );

    always_comb begin
        dp_d = dp_q;
        if (load) begin
            dp_d.sgn   = sgn_in;
            dp_d.mcand = x_in;
            dp_d.pp    = {{WIDTH{1'b0}}, y_in};
        end else if (step) begin
            dp_d.pp = {sum, dp_q.pp[WIDTH-1:1]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dp_q <= '0;
        else        dp_q <= dp_d;
    end

    assign pp = dp_q.pp;

    // R6
    mcand_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> $stable(dp_q.mcand) && $stable(dp_q.sgn));
    // R2
    load_step_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && step));

endmodule

// File: rtl/seq_shift_add_mul.sv
module seq_shift_add_mul #(
    parameter int WIDTH = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               sgn_mode,
    input  logic [WIDTH-1:0]   mcand,
    input  logic [WIDTH-1:0]   mplier,
    output logic               busy,
    output logic               done,
    output logic [2*WIDTH-1:0] product
);
    logic accept, step, last;

    mul_step_ctrl #(.WIDTH(WIDTH)) ctrl_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .accept (accept),
        .step   (step),
        .last   (last),
        .busy   (busy),
        .done   (done)
    );

    mul_pp_reg #(.WIDTH(WIDTH)) pp_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (accept),
        .step   (step),
        .last   (last),
        .sgn_in (sgn_mode),
        .x_in   (mcand),
        .y_in   (mplier),
        .pp     (product)
    );

    // R3
    fall_gives_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable(product));
    // R2
    start_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

endmodule

// File: tb/seq_shift_add_mul_tb_top.sv
module seq_shift_add_mul_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        s_start = 0, s_sgn = 0;
    logic [3:0]  s_x = 0, s_y = 0;
    logic        s_busy, s_done;
    logic [7:0]  s_prod;
    logic        w_start = 0, w_sgn = 0;
    logic [15:0] w_x = 0, w_y = 0;
    logic        w_busy, w_done;
    logic [31:0] w_prod;

    seq_shift_add_mul #(.WIDTH(4)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(s_start), .sgn_mode(s_sgn),
        .mcand(s_x), .mplier(s_y), .busy(s_busy), .done(s_done), .product(s_prod));

    seq_shift_add_mul #(.WIDTH(16)) dut_w_i (
        .clk(clk), .rst_n(rst_n), .start(w_start), .sgn_mode(w_sgn),
        .mcand(w_x), .mplier(w_y), .busy(w_busy), .done(w_done), .product(w_prod));

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] ref_mul(input int w, input logic [15:0] x,
                                            input logic [15:0] y, input bit s);
        longint a, b, m, r;
        m = (longint'(1) << w) - 1;
        a = longint'(x) & m;
        b = longint'(y) & m;
        if (s && x[w-1]) a = a - (longint'(1) << w);
        if (s && y[w-1]) b = b - (longint'(1) << w);
        r = (a * b) & ((longint'(1) << (2 * w)) - 1);
        return r[31:0];
    endfunction

    function automatic logic get_busy(input int w);
        return (w == 4) ? s_busy : w_busy;
    endfunction
    function automatic logic get_done(input int w);
        return (w == 4) ? s_done : w_done;
    endfunction
    function automatic logic [31:0] get_prod(input int w);
        return (w == 4) ? {24'd0, s_prod} : w_prod;
    endfunction

    task automatic drive(input int w, input logic st, input logic [15:0] x,
                         input logic [15:0] y, input bit s);
        if (w == 4) begin s_start = st; s_x = x[3:0]; s_y = y[3:0]; s_sgn = s; end
        else        begin w_start = st; w_x = x;      w_y = y;      w_sgn = s; end
    endtask

    // Called at a negedge; leaves the bench at the negedge where done is high.
    task automatic run(input int w, input logic [15:0] x, input logic [15:0] y,
                       input bit s, input string req);
        drive(w, 1'b1, x, y, s);
        @(negedge clk);
        drive(w, 1'b0, x, y, s);
        chk("R2", {31'd0, get_busy(w)}, 32'd1);
        repeat (w - 1) @(negedge clk);
        chk("R2", {31'd0, get_busy(w)}, 32'd1);
        @(negedge clk);
        chk("R3", {30'd0, get_busy(w), get_done(w)}, 32'd1);
        chk(req, get_prod(w), ref_mul(w, x, y, s));
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cyc);
            finish_up();
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R1
        chk("R1", {24'd0, s_busy, s_done, s_prod[5:0]}, 32'd0);
        chk("R1", w_prod, 32'd0);
        chk("R1", {30'd0, w_busy, w_done}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4 / R5 directed corners, narrow
        run(4, 16'hA, 16'h3, 1'b0, "R4");
        chk("R4", {24'd0, s_prod}, 32'h1E);
        @(negedge clk);
        chk("R3", {31'd0, s_done}, 32'd0);
        run(4, 16'hF, 16'hF, 1'b0, "R4");
        chk("R4", {24'd0, s_prod}, 32'hE1);
        @(negedge clk);
        run(4, 16'hA, 16'hB, 1'b1, "R5");
        chk("R5", {24'd0, s_prod}, 32'h1E);
        @(negedge clk);
        run(4, 16'h8, 16'h8, 1'b1, "R5");
        chk("R5", {24'd0, s_prod}, 32'h40);
        @(negedge clk);
        run(4, 16'h8, 16'h7, 1'b1, "R5");
        chk("R5", {24'd0, s_prod}, 32'hC8);

        // R8: start in the done cycle
        run(4, 16'h5, 16'h6, 1'b0, "R8");
        run(4, 16'hD, 16'h3, 1'b1, "R8");

        // R7: idle hold while inputs wander
        held = {24'd0, s_prod};
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            drive(4, 1'b0, 16'($urandom), 16'($urandom), 1'($urandom));
        end
        @(negedge clk);
        chk("R7", {24'd0, s_prod}, held);

        // R6: start while busy with other operands and mode
        drive(4, 1'b1, 16'h7, 16'h9, 1'b0);
        @(negedge clk);
        drive(4, 1'b1, 16'hF, 16'h1, 1'b1);
        @(negedge clk);
        drive(4, 1'b0, 16'h3, 16'h3, 1'b1);
        repeat (2) @(negedge clk);
        drive(4, 1'b1, 16'h2, 16'h2, 1'b1);
        @(negedge clk);
        drive(4, 1'b0, 16'h0, 16'h0, 1'b0);
        chk("R6", {30'd0, s_busy, s_done}, 32'd1);
        chk("R6", {24'd0, s_prod}, ref_mul(4, 16'h7, 16'h9, 1'b0));
        @(negedge clk);

        // R4 / R5 exhaustive narrow
        for (int m = 0; m < 2; m++)
            for (int a = 0; a < 16; a++)
                for (int b = 0; b < 16; b++) begin
                    run(4, 16'(a), 16'(b), 1'(m), (m == 1) ? "R5" : "R4");
                    @(negedge clk);
                end

        // Wide directed corners
        run(16, 16'hFFFF, 16'hFFFF, 1'b0, "R4");
        @(negedge clk);
        run(16, 16'h8000, 16'h8000, 1'b1, "R5");
        @(negedge clk);
        run(16, 16'h8000, 16'h7FFF, 1'b1, "R5");
        run(16, 16'h1234, 16'hFEDC, 1'b1, "R8");
        @(negedge clk);

        // Wide random
        for (int i = 0; i < 300; i++) begin
            logic [15:0] ra, rb;
            bit rs;
            ra = 16'($urandom);
            rb = 16'($urandom);
            rs = 1'($urandom);
            run(16, ra, rb, rs, rs ? "R5" : "R4");
            @(negedge clk);
        end

        finish_up();
    end

endmodule